// File: doc/BRIEF.md
# Vector Command Scoreboard Issuer

This block sits between a scalar control pipeline and a group of dedicated vector function units. Each unit runs one command for many cycles. The pipeline presents one decoded instruction at a time over a valid/ready handshake. An instruction is either a vector command, which names a function unit and a shared-memory bank, or a sync instruction, which names the tag of an earlier vector command.

A small scoreboard records every vector command in flight. For each one it keeps the unit, the bank and the tag. A new vector command is compared against every occupied entry in the same cycle. It is held back when its unit or its bank is already in use, or when every entry is occupied. Otherwise the issuer starts the unit and moves on without waiting for the unit to finish. Completion pulses from the units free their entries. A sync instruction is held until no occupied entry carries its tag.

The handshake is the only way in. A held instruction therefore blocks every instruction behind it, so issue order is kept and only execution overlaps.

Top module: `vsb_issuer`

## Requirements
- R1: After reset the scoreboard is empty, `unit_start_o` is all zero, `stall_o` is low and `cmd_tag_o` is 0.
- R2: A vector command (`cmd_kind_i` = 0) accepted at a clock edge produces, in the following cycle, a one-cycle pulse on `unit_start_o` at bit `cmd_unit_i` only, with `start_bank_o` equal to the accepted bank.
- R3: A vector command whose unit matches an occupied entry is not accepted: `cmd_ready_o` is low and `stall_o` is high while it is presented.
- R4: A vector command whose bank matches an occupied entry is not accepted, even when its unit is free.
- R5: When all DEPTH (default 4) entries are occupied, a vector command with no unit or bank conflict is still not accepted.
- R6: A done pulse on a unit frees that unit's entry at the same clock edge. A command stalled on that entry is therefore ready in the next cycle, not in the cycle of the pulse.
- R7: Issue does not wait for completion: non-conflicting vector commands are accepted on consecutive cycles.
- R8: Each accepted vector command takes the value on `cmd_tag_o` as its tag. `cmd_tag_o` then advances by 1, modulo 2^TAG_W (default 8).
- R9: A sync instruction (`cmd_kind_i` = 1) is ready only when no occupied entry has tag `cmd_wait_tag_i`. A sync naming a finished or unused tag is accepted at once. An accepted sync starts no unit.
- R10: While the presented instruction is stalled, no unit is started.
- R11: A done pulse on a unit that has no occupied entry changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | An instruction is presented |
| cmd_ready_o | output | 1 | The presented instruction can be accepted this cycle |
| cmd_kind_i | input | 1 | 0 = vector command, 1 = sync instruction |
| cmd_unit_i | input | UNIT_W (3) | Function unit named by a vector command |
| cmd_bank_i | input | BANK_W (3) | Shared-memory bank named by a vector command |
| cmd_wait_tag_i | input | TAG_W (3) | Tag awaited by a sync instruction |
| cmd_tag_o | output | TAG_W (3) | Tag the next accepted vector command receives |
| unit_done_i | input | NUM_UNITS (6) | One-cycle completion pulse per unit |
| unit_start_o | output | NUM_UNITS (6) | One-cycle start pulse per unit |
| start_bank_o | output | BANK_W (3) | Bank of the command being started |
| stall_o | output | 1 | An instruction is presented but held |

## Verification
The issue path is driven with four patterns. Two independent commands back to back show that issue is non-blocking. A unit-only clash and a bank-only clash separate the two comparisons. A clash-free command against a full scoreboard isolates the occupancy limit.

Done pulses are timed against a waiting command, which exposes an off-by-one in the release cycle. A stray done on an idle unit must leave the full scoreboard full. Sync instructions are tried on a live tag and on a retired one, and the tag counter is pushed across its wrap.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

    // Instruction kinds carried on cmd_kind_i.
    typedef enum logic {
        K_VECTOR = 1'b0,
        K_SYNC   = 1'b1
    } cmd_kind_e;

endpackage

// File: rtl/vsb_match.sv
// Parallel comparison of a candidate against every scoreboard entry.
module vsb_match #(
    parameter int DEPTH  = 4,
    parameter int UNIT_W = 3,
    parameter int BANK_W = 3,
    parameter int TAG_W  = 3
) (
    input  logic [DEPTH-1:0]             vld_i,
    input  logic [DEPTH-1:0][UNIT_W-1:0] unit_i,
    input  logic [DEPTH-1:0][BANK_W-1:0] bank_i,
    input  logic [DEPTH-1:0][TAG_W-1:0]  tag_i,
    input  logic [UNIT_W-1:0]            q_unit_i,
    input  logic [BANK_W-1:0]            q_bank_i,
    input  logic [TAG_W-1:0]             q_tag_i,
    output logic                         unit_hit_o,
    output logic                         bank_hit_o,
    output logic                         tag_hit_o
);

    logic [DEPTH-1:0] unit_eq;
    logic [DEPTH-1:0] bank_eq;
    logic [DEPTH-1:0] tag_eq;

    for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
        assign unit_eq[e] = vld_i[e] && (unit_i[e] == q_unit_i);
        assign bank_eq[e] = vld_i[e] && (bank_i[e] == q_bank_i);
        assign tag_eq[e]  = vld_i[e] && (tag_i[e]  == q_tag_i);
    end

    assign unit_hit_o = |unit_eq;
    assign bank_hit_o = |bank_eq;
    assign tag_hit_o  = |tag_eq;

endmodule

// File: rtl/vsb_alloc.sv
// Lowest-index free entry finder.
module vsb_alloc #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] vld_i,
    output logic             free_any_o,
    output logic [IDX_W-1:0] free_idx_o
);

    always_comb begin
        free_any_o = 1'b0;
        free_idx_o = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (!vld_i[e]) begin
                free_any_o = 1'b1;
                free_idx_o = IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/vsb_issuer.sv
module vsb_issuer #(
    parameter int NUM_UNITS = 6,
    parameter int NUM_BANKS = 8,
    parameter int DEPTH     = 4,
    parameter int TAG_W     = 3,
    localparam int UNIT_W   = $clog2(NUM_UNITS),
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cmd_valid_i,
    output logic                 cmd_ready_o,
    input  logic                 cmd_kind_i,
    input  logic [UNIT_W-1:0]    cmd_unit_i,
    input  logic [BANK_W-1:0]    cmd_bank_i,
    input  logic [TAG_W-1:0]     cmd_wait_tag_i,
    output logic [TAG_W-1:0]     cmd_tag_o,
    input  logic [NUM_UNITS-1:0] unit_done_i,
    output logic [NUM_UNITS-1:0] unit_start_o,
    output logic [BANK_W-1:0]    start_bank_o,
    output logic                 stall_o
);
    import vsb_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][UNIT_W-1:0] unit;
        logic [DEPTH-1:0][BANK_W-1:0] bank;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [TAG_W-1:0]             next_tag;
        logic [NUM_UNITS-1:0]         start;
        logic [BANK_W-1:0]            start_bank;
    } state_t;

    state_t s_d, s_q;

    logic             unit_hit, bank_hit, tag_hit;
    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic             is_sync;
    logic             accept;
    logic             accept_vec;
    logic [DEPTH-1:0] retire;

    vsb_match #(
        .DEPTH (DEPTH),
        .UNIT_W(UNIT_W),
        .BANK_W(BANK_W),
        .TAG_W (TAG_W)
    ) u_match (
        .vld_i     (s_q.vld),
        .unit_i    (s_q.unit),
        .bank_i    (s_q.bank),
        .tag_i     (s_q.tag),
        .q_unit_i  (cmd_unit_i),
        .q_bank_i  (cmd_bank_i),
        .q_tag_i   (cmd_wait_tag_i),
        .unit_hit_o(unit_hit),
        .bank_hit_o(bank_hit),
        .tag_hit_o (tag_hit)
    );

    vsb_alloc #(
        .DEPTH(DEPTH)
    ) u_alloc (
        .vld_i     (s_q.vld),
        .free_any_o(free_any),
        .free_idx_o(free_idx)
    );

    assign is_sync     = (cmd_kind_i == K_SYNC);
    assign cmd_ready_o = is_sync ? !tag_hit : (!unit_hit && !bank_hit && free_any);
    assign accept      = cmd_valid_i && cmd_ready_o;
    assign accept_vec  = accept && !is_sync;
    assign stall_o     = cmd_valid_i && !cmd_ready_o;

    // Completion pulses matched to the occupied entries.
    always_comb begin
        retire = '0;
        for (int e = 0; e < DEPTH; e++) begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (s_q.vld[e] && (s_q.unit[e] == UNIT_W'(u)) && unit_done_i[u]) begin
                    retire[e] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        s_d            = s_q;
        s_d.vld        = s_q.vld & ~retire;
        s_d.start      = '0;
        s_d.start_bank = s_q.start_bank;
        if (accept_vec) begin
            s_d.vld[free_idx]  = 1'b1;
            s_d.unit[free_idx] = cmd_unit_i;
            s_d.bank[free_idx] = cmd_bank_i;
            s_d.tag[free_idx]  = s_q.next_tag;
            s_d.next_tag       = s_q.next_tag + TAG_W'(1);
            s_d.start_bank     = cmd_bank_i;
            for (int u = 0; u < NUM_UNITS; u++) begin
                s_d.start[u] = (cmd_unit_i == UNIT_W'(u));
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_tag_o    = s_q.next_tag;
    assign unit_start_o = s_q.start;
    assign start_bank_o = s_q.start_bank;

    // Two occupied entries never name the same unit.
    logic dup_unit;
    always_comb begin
        dup_unit = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = a + 1; b < DEPTH; b++) begin
                if (s_q.vld[a] && s_q.vld[b] && (s_q.unit[a] == s_q.unit[b])) begin
                    dup_unit = 1'b1;
                end
            end
        end
    end

    AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(unit_start_o)); // R2

    AST_START_FROM_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|unit_start_o) |-> $past(cmd_valid_i && cmd_ready_o && cmd_kind_i == K_VECTOR)); // R2

    AST_NO_DUP_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dup_unit); // R3

    AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((&s_q.vld) && cmd_kind_i == K_VECTOR) |-> !cmd_ready_o); // R5

    AST_TAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_ready_o && cmd_kind_i == K_VECTOR)
        |=> (cmd_tag_o == $past(cmd_tag_o) + TAG_W'(1))); // R8

    AST_SYNC_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_ready_o && cmd_kind_i == K_SYNC) |=> (unit_start_o == '0)); // R9

    AST_STALL_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |=> (unit_start_o == '0)); // R10

endmodule

// File: tb/sim_vsb_issuer.sv
module sim_vsb_issuer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       valid;
    logic       ready;
    logic       kind;
    logic [2:0] unit;
    logic [2:0] bank;
    logic [2:0] wtag;
    logic [2:0] tag;
    logic [5:0] done;
    logic [5:0] start;
    logic [2:0] sbank;
    logic       stall;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vsb_issuer u0 (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cmd_valid_i   (valid),
        .cmd_ready_o   (ready),
        .cmd_kind_i    (kind),
        .cmd_unit_i    (unit),
        .cmd_bank_i    (bank),
        .cmd_wait_tag_i(wtag),
        .cmd_tag_o     (tag),
        .unit_done_i   (done),
        .unit_start_o  (start),
        .start_bank_o  (sbank),
        .stall_o       (stall)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Called at a negedge: present an instruction and let it settle.
    task automatic put(input bit v, input bit k, input int u, input int b, input int t);
        valid = v;
        kind  = k;
        unit  = 3'(u);
        bank  = 3'(b);
        wtag  = 3'(t);
        #1;
    endtask

    // Issue a vector command expected to be accepted at once.
    task automatic issue_ok(input int u, input int b, input int exp_tag, input string req);
        put(1, 0, u, b, 0);
        chk(ready == 1'b1, req, ready, 1);
        chk(tag == 3'(exp_tag), "R8", tag, exp_tag);
        step();
        chk(start == 6'(1 << u), req, start, 1 << u);
        chk(sbank == 3'(b), "R2", sbank, b);
        put(0, 0, 0, 0, 0);
    endtask

    // One-cycle done pulse on unit u while the held instruction stays presented.
    task automatic pulse_done(input int u);
        done = 6'(1 << u);
        #1;
        chk(ready == 1'b0, "R6", ready, 0);
        step();
        done = '0;
        #1;
    endtask

    task automatic t_reset();
        chk(start == 6'd0, "R1", start, 0);
        chk(stall == 1'b0, "R1", stall, 0);
        chk(tag == 3'd0, "R1", tag, 0);
        put(1, 0, 5, 7, 0);
        chk(ready == 1'b1, "R1", ready, 1);
        put(0, 0, 0, 0, 0);
    endtask

    task automatic t_back_to_back();
        issue_ok(0, 0, 0, "R2");
        issue_ok(1, 1, 1, "R7"); // R7 accepted the very next cycle
    endtask

    task automatic t_unit_clash();
        put(1, 0, 0, 2, 0);
        chk(ready == 1'b0, "R3", ready, 0);
        chk(stall == 1'b1, "R3", stall, 1);
        for (int i = 0; i < 3; i++) begin
            step();
            chk(start == 6'd0, "R10", start, 0);
        end
        pulse_done(0);
        chk(ready == 1'b1, "R6", ready, 1);
        issue_ok(0, 2, 2, "R6");
    endtask

    task automatic t_bank_clash();
        put(1, 0, 2, 1, 0);
        chk(ready == 1'b0, "R4", ready, 0);
        step();
        chk(start == 6'd0, "R10", start, 0);
        pulse_done(1);
        issue_ok(2, 1, 3, "R4");
    endtask

    task automatic t_full();
        issue_ok(3, 3, 4, "R2");
        issue_ok(4, 0, 5, "R2");
        put(1, 0, 5, 5, 0);
        chk(ready == 1'b0, "R5", ready, 0);
        chk(stall == 1'b1, "R5", stall, 1);
        pulse_done(3);
        issue_ok(5, 5, 6, "R5");
    endtask

    task automatic t_stray_done();
        put(1, 0, 3, 6, 0);
        chk(ready == 1'b0, "R11", ready, 0);
        done = 6'b000010;
        step();
        done = '0;
        #1;
        chk(ready == 1'b0, "R11", ready, 0);
        chk(start == 6'd0, "R11", start, 0);
        pulse_done(2);
        issue_ok(3, 6, 7, "R11");
    endtask

    task automatic t_sync();
        put(1, 1, 0, 0, 5);
        chk(ready == 1'b0, "R9", ready, 0);
        chk(stall == 1'b1, "R9", stall, 1);
        pulse_done(4);
        chk(ready == 1'b1, "R9", ready, 1);
        step();
        chk(start == 6'd0, "R9", start, 0);
        put(1, 1, 0, 0, 3);
        chk(ready == 1'b1, "R9", ready, 1);
        step();
        chk(start == 6'd0, "R9", start, 0);
        put(0, 0, 0, 0, 0);
        chk(tag == 3'd0, "R8", tag, 0); // wrap after tag 7
        issue_ok(4, 0, 0, "R8");
    endtask

    initial begin
        rst_n = 1'b0;
        valid = 1'b0;
        kind  = 1'b0;
        unit  = '0;
        bank  = '0;
        wtag  = '0;
        done  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_back_to_back();
        t_unit_clash();
        t_bank_clash();
        t_full();
        t_stray_done();
        t_sync();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule